// File: doc/BRIEF.md
# Configuration Bank Nonvolatile Transfer Controller

This block sits on a simple register bus and copies a bank of configuration words between a set of volatile shadow registers and a small nonvolatile store. Software reaches the shadow words directly on the bus. To move the whole bank into the store (a bank write) or to refill the shadows from it (a bank read), software must first stop the motor with the disable control bit and then load the unlock key. After that, it writes the transfer-control register with the bank-access field set. A status bit shows when the transfer is finished.

The nonvolatile store is modelled inside the block as a register array. Each word takes a fixed, parameterised number of cycles to transfer. Words move one after another, from the lowest index to the highest. The bus front end is a plain address, write-data and write-strobe port. Read data is combinational from the address.

Top module: `nvcfg_xfer_ctrl`

## Requirements
- R1: After reset the status register (0x32) reads 0x0001, and the key register (0x31), the motor-control register (0x60), the transfer-control register (0x35) and all shadow words read 0x0000. The store holds all zeros.
- R2: When idle, the shadow words at 0x90 up to 0x90+NUM_WORDS-1 (0x96 by default) accept writes and read back the value written.
- R3: The key register stores any 16-bit value written to it and reads it back. Access is unlocked only while it holds 0xC0DE, and writing 0x0000 locks it again.
- R4: Bit 15 of 0x60 is the motor-disable control. It reads back as bit 15, and the other bits read 0.
- R5: A write to 0x35 starts a transfer when bits [4:3] equal 2'b10, bit 2 (shadow enable) is 0 and bit 1 (refresh) is 0. Bit 0 set to 1 selects a bank write (shadow to store), and 0 selects a bank read (store to shadow). Bits [4:0] of the last accepted write read back at 0x35. The status bit 0 reads 0 from the cycle after the start.
- R6: A start request is ignored (status stays 1) unless the key register holds 0xC0DE and the motor-disable bit is 1 at the time of the write.
- R7: Status bit 0 reads 0 for exactly NUM_WORDS*PROG_CYC cycles after a start, then returns to 1.
- R8: A bank write followed by a bank read gives back, in every shadow word, the value it held when the bank write ran.
- R9: Words transfer in ascending index order. Word k is committed PROG_CYC*(k+1) clock edges after the start edge.
- R10: While a transfer is running, writes to 0x35 and to the shadow words are ignored.
- R11: Addresses outside the map, including the one just past the last shadow word, read 0x0000 and have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Register address for read and write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |

## Verification
The bench tries a start under each missing precondition: a wrong key, a cleared motor-disable bit, a wrong access mode and a set refresh bit. A design with a loose gate would drop the status bit there. It measures the busy window edge by edge and watches one shadow word change in the middle of a bank read. An off-by-one counter or a reversed word order would move that change to the wrong cycle. It also writes a shadow word and the control register during a transfer, and checks that the stored value and the restored bank are untouched. A design that leaks those writes would corrupt the store or restart the sequence.

// File: rtl/nvcfg_pkg.sv
// Shared register map, field positions and constants for the
// configuration-bank transfer controller. Assumes an 8-bit address space.
package nvcfg_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;

    localparam logic [ADDR_W-1:0] A_KEY  = 8'h31;
    localparam logic [ADDR_W-1:0] A_STAT = 8'h32;
    localparam logic [ADDR_W-1:0] A_ACC  = 8'h35;
    localparam logic [ADDR_W-1:0] A_MCTL = 8'h60;
    localparam logic [ADDR_W-1:0] A_SHD0 = 8'h90;

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 16'hC0DE;

    localparam int F_WREN    = 0;
    localparam int F_REFR    = 1;
    localparam int F_SHEN    = 2;
    localparam int F_MODE_LO = 3;
    localparam int F_MODE_HI = 4;
    localparam int ACC_W     = 5;
    localparam int MDIS_BIT  = 15;

    localparam logic [1:0] MODE_BANK = 2'b10;

    typedef enum logic {
        DIR_TO_SHD = 1'b0,
        DIR_TO_NV  = 1'b1
    } xfer_dir_e;
endpackage

// File: rtl/nvcfg_store.sv
// Nonvolatile word store model: one write port, one combinational read
// port, both addressed by the sequencer index. Assumes idx < NUM_WORDS.
module nvcfg_store
    import nvcfg_pkg::*;
#(
    parameter int NUM_WORDS = 7,
    localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [NUM_WORDS];

    // Per-word storage cells, cleared at reset to model a blank array.
    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem_q[g] <= '0;
            else if (we && idx == IDX_W'(g))
                mem_q[g] <= wdata;
        end
    end

    // Read port driven by the sequencer index.
    assign rdata = mem_q[idx];
endmodule

// File: rtl/nvcfg_seq.sv
// Transfer sequencer: once started, walks word indices upward, spending
// PROG_CYC cycles on each word and committing on its last cycle.
// Assumes start is only raised while idle.
module nvcfg_seq
    import nvcfg_pkg::*;
#(
    parameter int NUM_WORDS = 7,
    parameter int PROG_CYC  = 4,
    localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int CNT_W = (PROG_CYC > 1) ? $clog2(PROG_CYC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_dir,
    output logic             busy,
    output logic [IDX_W-1:0] idx,
    output logic             nv_we,
    output logic             shd_ld
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PROG_CYC - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_WORDS - 1);

    xfer_dir_e        dir_q;
    logic [CNT_W-1:0] cnt_q;
    logic             commit;

    // A word commits on the final cycle of its program window.
    assign commit = busy && (cnt_q == CNT_LAST);
    assign nv_we  = commit && (dir_q == DIR_TO_NV);
    assign shd_ld = commit && (dir_q == DIR_TO_SHD);

    // Busy flag, direction, per-word cycle counter and word index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            dir_q <= DIR_TO_SHD;
            cnt_q <= '0;
            idx   <= '0;
        end else if (!busy) begin
            if (start) begin
                busy  <= 1'b1;
                dir_q <= xfer_dir_e'(start_dir);
                cnt_q <= '0;
                idx   <= '0;
            end
        end else if (commit) begin
            cnt_q <= '0;
            if (idx == IDX_LAST)
                busy <= 1'b0;
            else
                idx <= idx + 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/nvcfg_regs.sv
// Register file: key, motor-control, transfer-control and the shadow bank,
// plus the read mux and the start decode. Assumes single-cycle bus writes.
module nvcfg_regs
    import nvcfg_pkg::*;
#(
    parameter int NUM_WORDS = 7,
    localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              busy,
    input  logic [IDX_W-1:0]  xfer_idx,
    input  logic              ld_en,
    input  logic [DATA_W-1:0] ld_data,
    output logic [DATA_W-1:0] sh_data,
    output logic              start,
    output logic              start_dir,
    output logic              unlocked,
    output logic              mtr_dis,
    output logic [ACC_W-1:0]  ctrl_q
);
    logic [DATA_W-1:0] key_q;
    logic [DATA_W-1:0] shd_q [NUM_WORDS];
    logic              acc_wr;
    logic              mode_ok;

    assign unlocked  = (key_q == UNLOCK_KEY);
    assign acc_wr    = bus_wr && !busy && (bus_addr == A_ACC);
    assign mode_ok   = (bus_wdata[F_MODE_HI:F_MODE_LO] == MODE_BANK)
                     && !bus_wdata[F_SHEN] && !bus_wdata[F_REFR];
    assign start     = acc_wr && mode_ok && unlocked && mtr_dis;
    assign start_dir = bus_wdata[F_WREN];
    assign sh_data   = shd_q[xfer_idx];

    // Key register: accepts any value at any time.
    always_ff @(posedge clk) begin
        if (!rst_n)
            key_q <= '0;
        else if (bus_wr && bus_addr == A_KEY)
            key_q <= bus_wdata;
    end

    // Motor-disable control bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mtr_dis <= 1'b0;
        else if (bus_wr && bus_addr == A_MCTL)
            mtr_dis <= bus_wdata[MDIS_BIT];
    end

    // Transfer-control fields, frozen while a transfer runs.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (acc_wr)
            ctrl_q <= bus_wdata[ACC_W-1:0];
    end

    // Shadow words: loaded by the sequencer or, when idle, by the bus.
    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_shd
        localparam logic [ADDR_W-1:0] MY_ADDR = A_SHD0 + ADDR_W'(g);
        always_ff @(posedge clk) begin
            if (!rst_n)
                shd_q[g] <= '0;
            else if (ld_en && xfer_idx == IDX_W'(g))
                shd_q[g] <= ld_data;
            else if (bus_wr && !busy && bus_addr == MY_ADDR)
                shd_q[g] <= bus_wdata;
        end
    end

    // Read mux; unmapped addresses return zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_KEY:   bus_rdata = key_q;
            A_STAT:  bus_rdata = {{(DATA_W-1){1'b0}}, ~busy};
            A_ACC:   bus_rdata = DATA_W'(ctrl_q);
            A_MCTL:  bus_rdata = {mtr_dis, {(DATA_W-1){1'b0}}};
            default: begin
                for (int k = 0; k < NUM_WORDS; k++)
                    if (bus_addr == A_SHD0 + ADDR_W'(k))
                        bus_rdata = shd_q[k];
            end
        endcase
    end
endmodule

// File: rtl/nvcfg_xfer_ctrl.sv
// Top: ties the register file, sequencer and store together. Assumes the
// shadow address window does not overlap the control registers.
module nvcfg_xfer_ctrl
    import nvcfg_pkg::*;
#(
    parameter int NUM_WORDS = 7,
    parameter int PROG_CYC  = 4,
    localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    logic              busy_w;
    logic [IDX_W-1:0]  idx_w;
    logic              nv_we_w;
    logic              shd_ld_w;
    logic              start_w;
    logic              start_dir_w;
    logic              unlocked_w;
    logic              mtr_dis_w;
    logic [ACC_W-1:0]  ctrl_w;
    logic [DATA_W-1:0] sh_data_w;
    logic [DATA_W-1:0] nv_data_w;

    nvcfg_regs #(.NUM_WORDS(NUM_WORDS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy_w),
        .xfer_idx  (idx_w),
        .ld_en     (shd_ld_w),
        .ld_data   (nv_data_w),
        .sh_data   (sh_data_w),
        .start     (start_w),
        .start_dir (start_dir_w),
        .unlocked  (unlocked_w),
        .mtr_dis   (mtr_dis_w),
        .ctrl_q    (ctrl_w)
    );

    nvcfg_seq #(.NUM_WORDS(NUM_WORDS), .PROG_CYC(PROG_CYC)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_w),
        .start_dir (start_dir_w),
        .busy      (busy_w),
        .idx       (idx_w),
        .nv_we     (nv_we_w),
        .shd_ld    (shd_ld_w)
    );

    nvcfg_store #(.NUM_WORDS(NUM_WORDS)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (nv_we_w),
        .idx   (idx_w),
        .wdata (sh_data_w),
        .rdata (nv_data_w)
    );
endmodule

// File: rtl/nvcfg_xfer_chk.sv
// Checker for the transfer controller, bound into every instance of the top.
module nvcfg_xfer_chk
    import nvcfg_pkg::*;
#(
    parameter int NUM_WORDS = 7,
    localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              busy,
    input logic [IDX_W-1:0]  idx,
    input logic              nv_we,
    input logic              shd_ld,
    input logic              unlocked,
    input logic              mtr_dis,
    input logic [ACC_W-1:0]  ctrl
);
    p_start_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_wr && bus_addr == A_ACC && unlocked && mtr_dis));

    p_single_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({nv_we, shd_ld}));

    p_commit_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_we || shd_ld) |-> busy);

    p_status_view_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_STAT) |-> (bus_rdata[0] == !busy));

    p_last_word_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (nv_we || shd_ld) && idx == IDX_W'(NUM_WORDS - 1)) |=> !busy);

    p_index_ascends_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (idx == $past(idx) || idx == $past(idx) + 1'b1));

    p_ctrl_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr && bus_addr == A_ACC) |=> (ctrl == $past(ctrl)));
endmodule

bind nvcfg_xfer_ctrl nvcfg_xfer_chk #(.NUM_WORDS(NUM_WORDS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .busy      (busy_w),
    .idx       (idx_w),
    .nv_we     (nv_we_w),
    .shd_ld    (shd_ld_w),
    .unlocked  (unlocked_w),
    .mtr_dis   (mtr_dis_w),
    .ctrl      (ctrl_w)
);

// File: tb/test_nvcfg_xfer_ctrl.sv
module test_nvcfg_xfer_ctrl;
    localparam int N = 7;
    localparam int P = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [15:0] bus_wdata = 16'h0000;
    logic [15:0] bus_rdata;

    int tests = 0;
    int fails = 0;

    // behavioural reference state
    logic [15:0] m_key, m_ctrl;
    logic        m_mdis, m_busy, m_dir, b_pre, unl_pre, md_pre;
    logic [15:0] m_shd [N];
    logic [15:0] m_nv  [N];
    int          m_cnt, m_idx;

    nvcfg_xfer_ctrl #(.NUM_WORDS(N), .PROG_CYC(P)) i_nvcfg_xfer_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #5 clk = ~clk;

    // Reference model, updated on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_key = 0; m_ctrl = 0; m_mdis = 0; m_busy = 0; m_dir = 0;
            m_cnt = 0; m_idx = 0;
            for (int k = 0; k < N; k++) begin m_shd[k] = 0; m_nv[k] = 0; end
        end else begin
            b_pre = m_busy; unl_pre = (m_key == 16'hC0DE); md_pre = m_mdis;
            if (b_pre) begin
                if (m_cnt == P - 1) begin
                    if (m_dir) m_nv[m_idx] = m_shd[m_idx];
                    else       m_shd[m_idx] = m_nv[m_idx];
                    m_cnt = 0;
                    if (m_idx == N - 1) m_busy = 0; else m_idx++;
                end else m_cnt++;
            end
            if (bus_wr) begin
                if (bus_addr == 8'h31) m_key = bus_wdata;
                else if (bus_addr == 8'h60) m_mdis = bus_wdata[15];
                else if (bus_addr == 8'h35 && !b_pre) begin
                    m_ctrl = {11'd0, bus_wdata[4:0]};
                    if (unl_pre && md_pre && bus_wdata[4:3] == 2'b10 && !bus_wdata[2] && !bus_wdata[1]) begin
                        m_busy = 1; m_dir = bus_wdata[0]; m_cnt = 0; m_idx = 0;
                    end
                end else if (bus_addr >= 8'h90 && bus_addr < 8'h90 + N && !b_pre)
                    m_shd[bus_addr - 8'h90] = bus_wdata;
            end
        end
    end

    function automatic logic [15:0] model_read(input logic [7:0] a);
        if (a == 8'h31) return m_key;
        if (a == 8'h32) return {15'd0, !m_busy};
        if (a == 8'h35) return m_ctrl;
        if (a == 8'h60) return {m_mdis, 15'd0};
        if (a >= 8'h90 && a < 8'h90 + N) return m_shd[a - 8'h90];
        return 16'h0000;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Read at the current negedge and compare with the model and a fixed value.
    task automatic rd(input logic [7:0] a, input logic [15:0] exp, input string req);
        bus_wr = 1'b0; bus_addr = a;
        #1;
        check(req, bus_rdata, model_read(a));
        check(req, bus_rdata, exp);
    endtask

    // Observe one address every cycle until the model is idle; compare each cycle.
    task automatic watch(input logic [7:0] a, input string req, output int busy_cycles, output int first_change);
        logic [15:0] v0;
        busy_cycles = 0; first_change = -1;
        bus_addr = a; #1; v0 = bus_rdata;
        for (int i = 0; i < 1000 && m_busy; i++) begin
            bus_addr = a; #1;
            check(req, bus_rdata, model_read(a));
            if (first_change < 0 && bus_rdata !== v0) first_change = i;
            busy_cycles++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int bc, fc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state, R11 unmapped
        rd(8'h32, 16'h0001, "R1 status");
        rd(8'h31, 16'h0000, "R1 key");
        rd(8'h60, 16'h0000, "R1 motor ctl");
        rd(8'h35, 16'h0000, "R1 ctrl");
        rd(8'h90, 16'h0000, "R1 shadow0");
        rd(8'h96, 16'h0000, "R1 shadow6");
        rd(8'h40, 16'h0000, "R11 unmapped");
        // R2 shadow access
        for (int k = 0; k < N; k++) wr(8'h90 + 8'(k), 16'h1000 + 16'(k) * 16'h0111);
        for (int k = 0; k < N; k++) rd(8'h90 + 8'(k), 16'h1000 + 16'(k) * 16'h0111, "R2 shadow rw");
        wr(8'h97, 16'hBEEF);
        rd(8'h97, 16'h0000, "R11 past last shadow");
        rd(8'h96, 16'h1666, "R11 neighbour untouched");
        // R6 gating
        wr(8'h35, 16'h0011);
        rd(8'h32, 16'h0001, "R6 locked, no disable");
        wr(8'h31, 16'hC0DE);
        rd(8'h31, 16'hC0DE, "R3 key readback");
        wr(8'h35, 16'h0011);
        rd(8'h32, 16'h0001, "R6 motor not disabled");
        wr(8'h60, 16'hFFFF);
        rd(8'h60, 16'h8000, "R4 disable bit");
        wr(8'h31, 16'h1234);
        wr(8'h35, 16'h0011);
        rd(8'h32, 16'h0001, "R6 wrong key");
        wr(8'h31, 16'h0000);
        wr(8'h31, 16'hC0DE);
        wr(8'h35, 16'h0009);
        rd(8'h32, 16'h0001, "R5 wrong mode");
        wr(8'h35, 16'h0013);
        rd(8'h32, 16'h0001, "R5 refresh set");
        wr(8'h35, 16'h0015);
        rd(8'h32, 16'h0001, "R5 shadow enable set");
        // R5/R7 bank write
        wr(8'h35, 16'h0011);
        rd(8'h32, 16'h0000, "R5 busy after start");
        watch(8'h32, "R7 status per cycle", bc, fc);
        check("R7 busy length", 16'(bc), 16'(N * P));
        rd(8'h32, 16'h0001, "R7 ready again");
        rd(8'h35, 16'h0011, "R5 ctrl readback");
        // R8/R9 bank read after clearing shadows
        for (int k = 0; k < N; k++) wr(8'h90 + 8'(k), 16'h0000);
        wr(8'h35, 16'h0010);
        watch(8'h93, "R9 shadow3 per cycle", bc, fc);
        check("R9 word3 commit cycle", 16'(fc), 16'(4 * P));
        for (int k = 0; k < N; k++) rd(8'h90 + 8'(k), 16'h1000 + 16'(k) * 16'h0111, "R8 restored");
        // R10 writes ignored while busy
        wr(8'h35, 16'h0011);
        wr(8'h92, 16'hDEAD);
        wr(8'h35, 16'h0010);
        rd(8'h92, 16'h1222, "R10 shadow write ignored");
        watch(8'h32, "R10 status per cycle", bc, fc);
        rd(8'h35, 16'h0011, "R10 ctrl write ignored");
        for (int k = 0; k < N; k++) wr(8'h90 + 8'(k), 16'h0000);
        wr(8'h35, 16'h0010);
        watch(8'h92, "R10 readback", bc, fc);
        rd(8'h92, 16'h1222, "R10 store intact");
        // R3 relock
        wr(8'h31, 16'h0000);
        wr(8'h35, 16'h0011);
        rd(8'h32, 16'h0001, "R3 relocked");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule